// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the low two bits of a memory address across a four-beat burst. When an access opens, a load strobe captures the two starting bits. After that the block steps to the next beat on each clock edge where an active-low step strobe is sampled low. The address stays inside an aligned group of four words. The upper address bits, the storage array and the bus control belong to other blocks.

The stepping order comes from a strap input that must not change while the block runs. With the strap low, the sequence counts up by one and wraps from 3 to 0. With the strap high, the sequence is the start value XOR a beat counter that runs 0, 1, 2, 3. Outside the block, an unconnected strap is pulled high, so interleaved order is the default.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after reset is released, `burst_addr` is 0.
- R2: When `load_i` is 1 at a rising edge, `burst_addr` takes the value of `start_addr_i` after that edge, whatever the values of `step_n_i` and `order_sel_i`.
- R3: In linear order (`order_sel_i` = 0), each edge where `step_n_i` = 0 and `load_i` = 0 sets `burst_addr` to (previous + 1) mod 4. For example, a start of 1 gives 1, 2, 3, 0.
- R4: In interleaved order (`order_sel_i` = 1), `burst_addr` equals start XOR beat, where beat is 0 on load and increases by one mod 4 on each step. For example, a start of 1 gives 1, 0, 3, 2.
- R5: At an edge where `load_i` = 1, the load wins over any step. The beat count restarts at 0.
- R6: At an edge where `load_i` = 0 and `step_n_i` = 1, `burst_addr` keeps its value.
- R7: The sequence wraps inside the four-word group. Four steps after a load, in either order, `burst_addr` is back at the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Captures the start address and restarts the beat count |
| start_addr_i | input | 2 | Low two bits of the first address in the burst |
| step_n_i | input | 1 | Active-low advance strobe |
| order_sel_i | input | 1 | Static strap: 0 for linear order, 1 for interleaved order |
| burst_addr | output | 2 | Current low address bits |

## Verification
A wrong start register or beat counter shows up on `burst_addr` at the first step after a load, with no delay. In interleaved mode, two steps are enough to tell an XOR sequence apart from a linear one. Starts of 1 and 3 make the two orders differ on the very next beat. A hold fault, or a load that loses to a step, shows up one edge after the stimulus. A wrap fault only shows on the fourth beat, so every burst is run through a full four steps.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef logic [ADDR_W-1:0] baddr_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  function automatic baddr_t beat_inc(input baddr_t b);
    return baddr_t'(b + baddr_t'(1));
  endfunction

  function automatic baddr_t map_addr(input order_e o, input baddr_t base, input baddr_t beat);
    if (o == ORDER_XOR) return base ^ beat;
    return baddr_t'(base + beat);
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   advance,
  output baddr_t beat
);
  baddr_t beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        beat_q <= '0;
    else if (restart)  beat_q <= '0;
    else if (advance)  beat_q <= beat_inc(beat_q);
  end

  assign beat = beat_q;

  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (beat == '0));
  a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> $stable(beat));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  baddr_t d,
  output baddr_t q
);
  baddr_t base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        base_q <= '0;
    else if (capture)  base_q <= d;
  end

  assign q = base_q;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (q == $past(d)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] start_addr_i,
  input  logic       step_n_i,
  input  logic       order_sel_i,
  output logic [1:0] burst_addr
);
  baddr_t base_w, beat_w;
  logic   step_ev;
  order_e order_w;

  assign step_ev = !step_n_i && !load_i;
  assign order_w = order_e'(order_sel_i);

  burst_base_reg u_base (
    .clk(clk), .rst_n(rst_n), .capture(load_i), .d(start_addr_i), .q(base_w)
  );

  burst_beat_ctr u_beat (
    .clk(clk), .rst_n(rst_n), .restart(load_i), .advance(step_ev), .beat(beat_w)
  );

  assign burst_addr = map_addr(order_w, base_w, beat_w);

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !order_sel_i && $stable(order_sel_i)) |=>
      (burst_addr == baddr_t'($past(burst_addr) + 2'd1)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_n_i && $stable(order_sel_i)) |=> $stable(burst_addr));
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (burst_addr == $past(start_addr_i)));
  a_r4_xor_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && order_sel_i && $stable(order_sel_i)) |=>
      ((burst_addr ^ $past(burst_addr)) == (beat_w ^ $past(beat_w))));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  logic clk = 0, rst_n = 0, load_i = 0, step_n_i = 1, order_sel_i = 1;
  logic [1:0] start_addr_i = 0;
  logic [1:0] burst_addr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (.*);

  task automatic chk(input string req, input logic [1:0] exp);
    checks++;
    if (burst_addr !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, burst_addr, exp);
    end
  endtask

  task automatic cyc(input logic ld, input logic [1:0] s, input logic stn);
    @(negedge clk);
    load_i = ld; start_addr_i = s; step_n_i = stn;
    @(negedge clk);
    load_i = 0; step_n_i = 1;
  endtask

  function automatic logic [1:0] model(input logic m, input logic [1:0] s, input int b);
    logic [1:0] bb = 2'(b);
    return m ? (s ^ bb) : 2'(s + bb);
  endfunction

  task automatic run_burst(input logic m, input logic [1:0] s, input string req);
    order_sel_i = m;
    cyc(1, s, 1);
    chk("R2", s);
    for (int k = 1; k <= 4; k++) begin
      cyc(0, 2'd0, 0);
      chk(k == 4 ? "R7" : req, model(m, s, k));
    end
  endtask

  task automatic t_reset();
    @(negedge clk); chk("R1", 2'd0);
    rst_n = 1;
    @(negedge clk); chk("R1", 2'd0);
  endtask

  task automatic t_hold();
    order_sel_i = 0;
    cyc(1, 2'd2, 1);
    cyc(0, 2'd0, 0);
    cyc(0, 2'd1, 1); chk("R6", 2'd3);
    cyc(0, 2'd0, 1); chk("R6", 2'd3);
  endtask

  task automatic t_load_wins();
    order_sel_i = 1;
    cyc(1, 2'd1, 1);
    cyc(0, 2'd0, 0);
    cyc(0, 2'd0, 0);
    chk("R4", 2'd3);
    cyc(1, 2'd2, 0); chk("R5", 2'd2);
    cyc(0, 2'd0, 0); chk("R5", 2'd3);
    order_sel_i = 0;
    cyc(1, 2'd3, 0); chk("R5", 2'd3);
    cyc(0, 2'd0, 0); chk("R3", 2'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_burst(0, 2'd1, "R3");
        run_burst(0, 2'd3, "R3");
        run_burst(1, 2'd1, "R4");
        run_burst(1, 2'd2, "R4");
        run_burst(1, 2'd3, "R4");
        t_hold();
        t_load_wins();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule